// File: doc/BRIEF.md
# Manchester Nibble Line Codec

This block sits between a 4-bit nibble interface and a one-wire Manchester line at the 10 Mb/s rate. On the transmit side it accepts one nibble per nibble period. It shifts the nibble out least-significant bit first and drives each data bit as a pair of half-cells with opposite levels. On the receive side it samples an already cell-aligned Manchester stream once per half-cell, decodes each bit cell and regroups the bits into nibbles. Each good nibble is announced with a one-cycle strobe.

Everything runs from one fast clock. A divider makes a half-cell enable every `HALF_DIV` clocks, for example 20 MHz from an 80 MHz clock. Two half-cells form a bit cell, and `NIB_W` bit cells form a nibble period, which gives 2.5 MHz at the defaults. Transmit and receive share this half-cell timing, so the receiver's cell boundaries are the transmitter's cell boundaries.

Top module: `manchester_codec`

## Requirements
- R1: `txTake` is high for exactly one clock, in the last clock of each nibble period (a period is `2*NIB_W*HALF_DIV` clocks), and only if `txValid` is high in that clock. `txNibble` is captured in that clock.
- R2: `txLine` changes only on a half-cell boundary, that is on the clock edge that ends a run of `HALF_DIV` clocks.
- R3: A captured nibble is sent during the nibble period that follows its capture, least-significant bit first. A 1 bit is low for the first half-cell and high for the second. A 0 bit is high for the first half-cell and low for the second.
- R4: If `txValid` is low at a nibble boundary, `txLine` stays low for the whole following nibble period and `txTake` does not fire.
- R5: `rxLine` is sampled once per half-cell, on the edge that ends it, and the second-half sample is the data bit. Bits are reassembled least-significant bit first. After a nibble period with no violation, `rxNibble` shows the nibble and `rxStrobe` is high for one clock, starting the clock after the last sample.
- R6: If any bit cell of a nibble period has equal half-cell samples, and the period is not all low, `rxViolation` pulses for one clock in place of `rxStrobe`. `rxNibble` keeps its old value.
- R7: A nibble period in which every half-cell sample is low counts as idle. It raises neither `rxStrobe` nor `rxViolation`.
- R8: `rxNibble` changes only in a clock where `rxStrobe` is high.
- R9: While `rstN` is low, `txLine`, `txTake`, `rxStrobe` and `rxViolation` are low and `rxNibble` is 0. The first nibble boundary falls in clock `2*NIB_W*HALF_DIV` after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all rates derived by enables |
| rstN | input | 1 | Asynchronous active-low reset |
| txNibble | input | NIB_W | Nibble to transmit |
| txValid | input | 1 | `txNibble` is valid for capture |
| txTake | output | 1 | One-clock pulse: nibble captured this clock |
| txLine | output | 1 | Manchester line output, low when idle |
| rxLine | input | 1 | Cell-aligned Manchester line input |
| rxNibble | output | NIB_W | Last good received nibble |
| rxStrobe | output | 1 | One-clock pulse: new good nibble on `rxNibble` |
| rxViolation | output | 1 | One-clock pulse: nibble dropped on a code violation |

## Verification
The assertions check the following on every cycle:
- the line moves only on half-cell boundaries;
- the line flips at mid-cell while a nibble is being sent;
- the line stays low after a boundary with no valid nibble;
- the receive strobe and the violation flag are mutually exclusive single pulses;
- `rxNibble` changes only together with the strobe.

Some properties can only be shown by the bench's scenarios:
- the exact capture clock;
- the bit order and level coding of whole nibbles, checked in loopback across many values;
- the dropping of nibbles that carry stuck-high or stuck-low cells;
- the treatment of an all-low period as idle.

// File: rtl/mcodec_pkg.sv
package mcodec_pkg;

  // Timing strobes handed from the rate control to the datapath.
  typedef struct packed {
    logic halfEn;     // last clock of a half-cell
    logic firstHalf;  // current half-cell is the first of its bit cell
    logic nibEnd;     // last clock of a nibble period
  } cellStrobe_t;

endpackage

// File: rtl/mcodec_ctrl.sv
module mcodec_ctrl
  import mcodec_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned NIB_W    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  output cellStrobe_t strb
);

  localparam int unsigned SLOTS  = 2 * NIB_W;
  localparam int unsigned DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam bit          SLOT_POW2 = ((SLOTS & (SLOTS - 1)) == 0);

  logic [DIV_W-1:0]  divCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic              halfEn;
  logic              lastSlot;

  assign halfEn   = (divCnt == DIV_W'(HALF_DIV - 1));
  assign lastSlot = (slotCnt == SLOT_W'(SLOTS - 1));

  // Half-cell divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       divCnt <= '0;
    else if (halfEn) divCnt <= '0;
    else             divCnt <= divCnt + 1'b1;
  end

  // Half-cell slot within the nibble period
  generate
    if (SLOT_POW2) begin : g_wrapNatural
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       slotCnt <= '0;
        else if (halfEn) slotCnt <= slotCnt + 1'b1;
      end
    end else begin : g_wrapExplicit
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                     slotCnt <= '0;
        else if (halfEn && lastSlot)   slotCnt <= '0;
        else if (halfEn)               slotCnt <= slotCnt + 1'b1;
      end
    end
  endgenerate

  assign strb.halfEn    = halfEn;
  assign strb.firstHalf = ~slotCnt[0];
  assign strb.nibEnd    = halfEn & lastSlot;

  AST_HALF_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (HALF_DIV > 1 && halfEn) |=> !halfEn); // R2

endmodule

// File: rtl/mcodec_dp.sv
module mcodec_dp
  import mcodec_pkg::*;
#(
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  cellStrobe_t      strb,
  input  logic [NIB_W-1:0] txNibble,
  input  logic             txValid,
  output logic             txTake,
  output logic             txLine,
  input  logic             rxLine,
  output logic [NIB_W-1:0] rxNibble,
  output logic             rxStrobe,
  output logic             rxViolation
);

  // ---------------- transmit ----------------
  logic [NIB_W-1:0] txShift;
  logic             txAct;
  logic             cellEnd;

  assign cellEnd = strb.halfEn & ~strb.firstHalf;
  assign txTake  = strb.nibEnd & txValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      txAct   <= 1'b0;
    end else if (strb.nibEnd) begin
      txAct   <= txValid;
      txShift <= txValid ? txNibble : '0;
    end else if (cellEnd) begin
      txShift <= txShift >> 1;
    end
  end

  // Data 1: low then high; data 0: high then low
  assign txLine = txAct & (strb.firstHalf ? ~txShift[0] : txShift[0]);

  AST_IDLE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.nibEnd && !txValid) |=> !txLine); // R4
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.halfEn |=> $stable(txLine)); // R2
  AST_MID_CELL_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.halfEn && strb.firstHalf && txAct) |=> (txLine != $past(txLine))); // R3

  // ---------------- receive ----------------
  logic             firstSample;
  logic [NIB_W-1:0] rxAcc;
  logic             violSeen;
  logic             highSeen;
  logic             cellBad;
  logic             nibBad;
  logic             nibIdle;
  logic [NIB_W-1:0] rxAsm;

  assign cellBad = (rxLine == firstSample);
  assign nibBad  = violSeen | cellBad;
  assign nibIdle = ~(highSeen | rxLine);
  assign rxAsm   = {rxLine, rxAcc[NIB_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstSample <= 1'b0;
      rxAcc       <= '0;
      violSeen    <= 1'b0;
      highSeen    <= 1'b0;
      rxNibble    <= '0;
      rxStrobe    <= 1'b0;
      rxViolation <= 1'b0;
    end else begin
      rxStrobe    <= 1'b0;
      rxViolation <= 1'b0;
      if (strb.halfEn) begin
        highSeen <= highSeen | rxLine;
        if (strb.firstHalf) begin
          firstSample <= rxLine;
        end else begin
          rxAcc    <= rxAsm;
          violSeen <= violSeen | cellBad;
        end
      end
      if (strb.nibEnd) begin
        rxStrobe    <= ~nibBad;
        rxViolation <= nibBad & ~nibIdle;
        if (!nibBad) rxNibble <= rxAsm;
        violSeen    <= 1'b0;
        highSeen    <= 1'b0;
      end
    end
  end

  AST_RX_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxStrobe, rxViolation})); // R6
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |=> !rxStrobe); // R5
  AST_NIB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxNibble != $past(rxNibble)) |-> rxStrobe); // R8

endmodule

// File: rtl/manchester_codec.sv
module manchester_codec
  import mcodec_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned NIB_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NIB_W-1:0] txNibble,
  input  logic             txValid,
  output logic             txTake,
  output logic             txLine,
  input  logic             rxLine,
  output logic [NIB_W-1:0] rxNibble,
  output logic             rxStrobe,
  output logic             rxViolation
);

  cellStrobe_t strb;

  mcodec_ctrl #(.HALF_DIV(HALF_DIV), .NIB_W(NIB_W)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb)
  );

  mcodec_dp #(.NIB_W(NIB_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .txNibble    (txNibble),
    .txValid     (txValid),
    .txTake      (txTake),
    .txLine      (txLine),
    .rxLine      (rxLine),
    .rxNibble    (rxNibble),
    .rxStrobe    (rxStrobe),
    .rxViolation (rxViolation)
  );

endmodule

// File: tb/sim_manchester_codec.sv
module sim_manchester_codec;

  localparam int D     = 2;
  localparam int N     = 4;
  localparam int SLOTS = 2 * N;
  localparam int PER   = SLOTS * D;
  localparam int LAST_K = 62;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0] txNibble = '0;
  logic         txValid = 1'b0;
  logic         txTake, txLine, rxLine, rxStrobe, rxViolation;
  logic [N-1:0] rxNibble;
  logic         loopback = 1'b1;
  logic         rxForce = 1'b0;

  assign rxLine = loopback ? txLine : rxForce;

  int total = 0;
  int bad = 0;
  int edgeCnt = 0;
  bit finished = 1'b0;

  manchester_codec #(.HALF_DIV(D), .NIB_W(N)) u0 (
    .clk(clk), .rstN(rstN), .txNibble(txNibble), .txValid(txValid),
    .txTake(txTake), .txLine(txLine), .rxLine(rxLine), .rxNibble(rxNibble),
    .rxStrobe(rxStrobe), .rxViolation(rxViolation)
  );

  always @(posedge clk) if (rstN) edgeCnt <= edgeCnt + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Stimulus plans per nibble period k
  function automatic bit planValid(int k);
    return (k >= 4) && (k % 5 != 0);
  endfunction

  function automatic logic [N-1:0] planNib(int k);
    return N'((k * 5 + 3) % 16);
  endfunction

  function automatic logic [SLOTS-1:0] rxPattern(int k);
    logic [SLOTS-1:0] p;
    logic [N-1:0] v;
    int hit;
    v = N'((k * 3 + 1) % 16);
    for (int b = 0; b < N; b++) begin
      p[2*b]   = ~v[b];
      p[2*b+1] = v[b];
    end
    hit = (k / 4) % N;
    case (k % 4)
      1: begin p[2*hit] = 1'b1; p[2*hit+1] = 1'b1; end
      2: begin p[2*hit] = 1'b0; p[2*hit+1] = 1'b0; end
      3: p = '0;
      default: ;
    endcase
    return p;
  endfunction

  // Reference model state
  logic         mAct = 1'b0;
  logic [N-1:0] mNib = '0;
  logic [SLOTS-1:0] halves = '0;
  logic         eStrobe = 1'b0;
  logic         eViol = 1'b0;
  logic [N-1:0] eNib = '0;

  always @(negedge clk) begin
    if (rstN && !finished) begin : model
      int n;
      int slot;
      logic expLine, expTake, rxIn, nbad, nidle;
      logic [N-1:0] asm;
      n = edgeCnt;
      slot = (n / D) % SLOTS;
      expLine = mAct ? ((slot % 2 == 1) ? mNib[slot/2] : ~mNib[slot/2]) : 1'b0;
      check(mAct ? "R3 line coding" : "R4 idle line", txLine, expLine);
      expTake = (n % D == D - 1) && (slot == SLOTS - 1) && txValid;
      check("R1 take", txTake, expTake);
      check(eStrobe ? "R5 strobe" : "R7 no strobe", rxStrobe, eStrobe);
      check("R6 violation", rxViolation, eViol);
      check("R8 rx nibble", rxNibble, eNib);
      rxIn = loopback ? expLine : rxForce;
      eStrobe = 1'b0;
      eViol = 1'b0;
      if (n % D == D - 1) begin
        halves[slot] = rxIn;
        if (slot == SLOTS - 1) begin
          nbad = 1'b0;
          for (int b = 0; b < N; b++) begin
            if (halves[2*b] == halves[2*b+1]) nbad = 1'b1;
            asm[b] = halves[2*b+1];
          end
          nidle = (halves == '0);
          eStrobe = !nbad;
          eViol = nbad && !nidle;
          if (!nbad) eNib = asm;
          mAct = txValid;
          mNib = txNibble;
        end
      end
    end
  end

  initial begin
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset line", txLine, 0);
    check("R9 reset take", txTake, 0);
    check("R9 reset strobe", rxStrobe, 0);
    check("R9 reset violation", rxViolation, 0);
    check("R9 reset nibble", rxNibble, 0);
    rstN = 1'b1;
    while (edgeCnt < LAST_K * PER) begin
      @(posedge clk);
      #2;
      begin : drive
        int k;
        int slot;
        logic [SLOTS-1:0] pat;
        k = edgeCnt / PER;
        slot = (edgeCnt / D) % SLOTS;
        txValid = planValid(k);
        txNibble = planNib(k);
        loopback = (k < 40);
        pat = rxPattern(k);
        rxForce = pat[slot];
      end
    end
    @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", edgeCnt, LAST_K * PER);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule